// File: doc/BRIEF.md
# Synchronous Dual-Port Memory

This block is a true dual-port word memory with two symmetric ports, called left and right. Each port has its own chip enables, read/write select, output enable, address, write data, read data and a per-port latency mode. Both ports run from one shared clock. Every control, address and write-data input is captured into a register on the rising edge. Either port may reach any word in any cycle, including the word the other port is using at that moment.

A port is selected only when its active-low enable is low and its active-high enable is high. On a selected cycle, the read/write select picks between storing the write data and fetching the addressed word. In flow-through mode, a read returns data in the cycle right after its inputs are captured. In pipelined mode, the data passes through one more output register and appears one cycle later.

A tri-state bus is not used. Each port drives its data on a plain output and raises a separate valid flag in place of a high-impedance state. The output enable gates that flag without waiting for a clock edge. The depth is `2**ADDR_W` words; the full-size build uses `ADDR_W = 15` for 32768 words of 8 bits.

Top module: `dpram_dual_sync`

## Requirements
- R1: The memory holds `2**ADDR_W` words of `DATA_W` bits, and a word written at any address, including address 0 and the highest address, is read back unchanged from either port.
- R2: A port is selected only when `*_ce0_n` = 0 and `*_ce1` = 1. With any other combination the port writes nothing and its `*_rvalid` stays 0 for that cycle's output.
- R3: On a selected cycle with `*_rw` = 0, `*_wdata` is stored at `*_addr` at the next edge, and `*_rvalid` is 0 for that cycle's output.
- R4: With `*_pipe` = 0 (flow-through), a read whose inputs are captured at edge k drives `*_rdata` and `*_rvalid` = 1 between edge k and edge k+1. A cycle with no read gives `*_rvalid` = 0.
- R5: With `*_pipe` = 1 (pipelined), a read captured at edge k drives `*_rdata` and `*_rvalid` = 1 between edge k+1 and edge k+2.
- R6: `*_oe_n` acts without a clock. While it is 1, `*_rvalid` is 0 even during a selected read, and lowering it restores the flag at once.
- R7: In pipelined mode, the output register keeps its last read word through cycles that are deselected or that write, while `*_rvalid` is 0.
- R8: When both ports write the same address in the same cycle, the left port's data is stored.
- R9: When one port reads an address that the other port writes in the same cycle, the read returns the contents from before the write, and a later read returns the new data.
- R10: The synchronous active-low reset `rst_n` clears the captured controls, both `*_rvalid` flags and the pipelined output registers to 0. Memory contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both ports, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| lft_ce0_n | input | 1 | Left active-low chip enable |
| lft_ce1 | input | 1 | Left active-high chip enable |
| lft_rw | input | 1 | Left select: 1 read, 0 write |
| lft_oe_n | input | 1 | Left asynchronous active-low output enable |
| lft_pipe | input | 1 | Left mode: 1 pipelined, 0 flow-through |
| lft_addr | input | ADDR_W | Left word address |
| lft_wdata | input | DATA_W | Left write data |
| lft_rdata | output | DATA_W | Left read data |
| lft_rvalid | output | 1 | Left read data valid (stands for a driven bus) |
| rgt_ce0_n | input | 1 | Right active-low chip enable |
| rgt_ce1 | input | 1 | Right active-high chip enable |
| rgt_rw | input | 1 | Right select: 1 read, 0 write |
| rgt_oe_n | input | 1 | Right asynchronous active-low output enable |
| rgt_pipe | input | 1 | Right mode: 1 pipelined, 0 flow-through |
| rgt_addr | input | ADDR_W | Right word address |
| rgt_wdata | input | DATA_W | Right write data |
| rgt_rdata | output | DATA_W | Right read data |
| rgt_rvalid | output | 1 | Right read data valid (stands for a driven bus) |

## Verification
On every cycle, the assertions check these relations, all measured at the ports:
- the valid flag of each port against the enable decode from one edge earlier (flow-through) or two edges earlier (pipelined);
- the immediate effect of the output enable;
- that the pipelined read word is held across cycles with no read.

Some behaviours depend on stored contents, and only the directed scenarios can show them: that a word survives at the lowest and highest addresses, that a deselected write leaves memory untouched, that the left port wins a write-write collision, and that a read racing a write returns the old word.

// File: rtl/dpram_pkg.sv
// Package: shared control type for the dual-port memory.
// Assumes: both ports use the same decoded control layout.
package dpram_pkg;

    // Decoded and registered per-port control for one cycle.
    typedef struct packed {
        logic wr;    // selected write
        logic rd;    // selected read
        logic pipe;  // 1 = pipelined output, 0 = flow-through
    } port_ctl_t;

endpackage

// File: rtl/dpram_port_in.sv
// Module: input capture and enable decode for one port.
// Captures enables, direction, mode, address and write data on the rising
// edge and turns them into a selected-write / selected-read pair.
// Assumes: synchronous active-low reset; all inputs are meant to be sampled.
module dpram_port_in
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce0_n,
    input  logic              ce1,
    input  logic              rw,
    input  logic              pipe,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output port_ctl_t         ctl_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q
);

    logic selected;

    // Decode: both enables must agree for the port to be selected.
    always_comb begin
        selected = ~ce0_n & ce1;
    end

    // Register the decoded control, address and data on every edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            ctl_q.wr   <= selected & ~rw;
            ctl_q.rd   <= selected & rw;
            ctl_q.pipe <= pipe;
            addr_q     <= addr;
            wdata_q    <= wdata;
        end
    end

endmodule

// File: rtl/dpram_array.sv
// Module: two-port word storage with combinational read on each port.
// Writes commit at the edge after capture; reads see the stored word
// until then, so a same-cycle read of a written word returns old data.
// Assumes: one shared clock; the left write is applied last and so wins.
module dpram_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              l_we,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    input  logic              r_we,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic [DATA_W-1:0] r_rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Write both ports; left comes second so it takes a shared address.
    always_ff @(posedge clk) begin
        if (r_we) begin
            mem[r_addr] <= r_wdata;
        end
        if (l_we) begin
            mem[l_addr] <= l_wdata;
        end
    end

    // Read both ports from the current contents.
    always_comb begin
        l_rdata = mem[l_addr];
        r_rdata = mem[r_addr];
    end

endmodule

// File: rtl/dpram_out_stage.sv
// Module: per-port read output latency select and output-enable gating.
// Flow-through passes the array word straight out; pipelined passes it
// through one register that only loads on a read and otherwise holds.
// Assumes: the mode bit arrives already registered with the read.
module dpram_out_stage
    import dpram_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  port_ctl_t         ctl_q,
    input  logic [DATA_W-1:0] arr_rdata,
    input  logic              oe_n,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    logic [DATA_W-1:0] pipe_data;
    logic              pipe_vld;

    // Pipeline register: load on a selected read, hold the word otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_data <= '0;
            pipe_vld  <= 1'b0;
        end else begin
            pipe_vld <= ctl_q.rd;
            if (ctl_q.rd) begin
                pipe_data <= arr_rdata;
            end
        end
    end

    // Pick the latency path and gate the valid flag with the output enable.
    always_comb begin
        if (ctl_q.pipe) begin
            rdata  = pipe_data;
            rvalid = pipe_vld & ~oe_n;
        end else begin
            rdata  = arr_rdata;
            rvalid = ctl_q.rd & ~oe_n;
        end
    end

endmodule

// File: rtl/dpram_dual_sync.sv
// Module: top of the synchronous dual-port memory.
// Two symmetric ports share one clock and one storage array. Each port
// captures its inputs, decodes its enables and picks its read latency.
// Assumes: synchronous active-low reset; the valid flag stands in for a
// tri-state bus, and the output enable acts without a clock.
module dpram_dual_sync
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lft_ce0_n,
    input  logic              lft_ce1,
    input  logic              lft_rw,
    input  logic              lft_oe_n,
    input  logic              lft_pipe,
    input  logic [ADDR_W-1:0] lft_addr,
    input  logic [DATA_W-1:0] lft_wdata,
    output logic [DATA_W-1:0] lft_rdata,
    output logic              lft_rvalid,
    input  logic              rgt_ce0_n,
    input  logic              rgt_ce1,
    input  logic              rgt_rw,
    input  logic              rgt_oe_n,
    input  logic              rgt_pipe,
    input  logic [ADDR_W-1:0] rgt_addr,
    input  logic [DATA_W-1:0] rgt_wdata,
    output logic [DATA_W-1:0] rgt_rdata,
    output logic              rgt_rvalid
);

    port_ctl_t         l_ctl,   r_ctl;
    logic [ADDR_W-1:0] l_addr_q, r_addr_q;
    logic [DATA_W-1:0] l_wd_q,  r_wd_q;
    logic [DATA_W-1:0] l_arr,   r_arr;

    dpram_port_in #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_lft_in (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce0_n   (lft_ce0_n),
        .ce1     (lft_ce1),
        .rw      (lft_rw),
        .pipe    (lft_pipe),
        .addr    (lft_addr),
        .wdata   (lft_wdata),
        .ctl_q   (l_ctl),
        .addr_q  (l_addr_q),
        .wdata_q (l_wd_q)
    );

    dpram_port_in #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rgt_in (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce0_n   (rgt_ce0_n),
        .ce1     (rgt_ce1),
        .rw      (rgt_rw),
        .pipe    (rgt_pipe),
        .addr    (rgt_addr),
        .wdata   (rgt_wdata),
        .ctl_q   (r_ctl),
        .addr_q  (r_addr_q),
        .wdata_q (r_wd_q)
    );

    dpram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk     (clk),
        .l_we    (l_ctl.wr),
        .l_addr  (l_addr_q),
        .l_wdata (l_wd_q),
        .r_we    (r_ctl.wr),
        .r_addr  (r_addr_q),
        .r_wdata (r_wd_q),
        .l_rdata (l_arr),
        .r_rdata (r_arr)
    );

    dpram_out_stage #(.DATA_W(DATA_W)) u_lft_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_q     (l_ctl),
        .arr_rdata (l_arr),
        .oe_n      (lft_oe_n),
        .rdata     (lft_rdata),
        .rvalid    (lft_rvalid)
    );

    dpram_out_stage #(.DATA_W(DATA_W)) u_rgt_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_q     (r_ctl),
        .arr_rdata (r_arr),
        .oe_n      (rgt_oe_n),
        .rdata     (rgt_rdata),
        .rvalid    (rgt_rvalid)
    );

endmodule

// File: rtl/dpram_dual_sync_chk.sv
// Checker: port-level timing rules of the dual-port memory, bound to the top.
// Assumes: synchronous active-low reset; all checks look only at ports.
module dpram_dual_sync_chk #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lft_ce0_n,
    input logic              lft_ce1,
    input logic              lft_rw,
    input logic              lft_oe_n,
    input logic              lft_pipe,
    input logic [DATA_W-1:0] lft_rdata,
    input logic              lft_rvalid,
    input logic              rgt_ce0_n,
    input logic              rgt_ce1,
    input logic              rgt_rw,
    input logic              rgt_oe_n,
    input logic              rgt_pipe,
    input logic [DATA_W-1:0] rgt_rdata,
    input logic              rgt_rvalid
);

    localparam int AW_UNUSED = ADDR_W;

    logic l_rd_in, r_rd_in;

    // Selected-read decode of the raw port inputs.
    always_comb begin
        l_rd_in = ~lft_ce0_n & lft_ce1 & lft_rw;
        r_rd_in = ~rgt_ce0_n & rgt_ce1 & rgt_rw;
    end

    // R6: output enable high forces the valid flag low.
    a_r6_lft_oe_gates: assert property (@(posedge clk) disable iff (!rst_n)
        lft_oe_n |-> !lft_rvalid);
    a_r6_rgt_oe_gates: assert property (@(posedge clk) disable iff (!rst_n)
        rgt_oe_n |-> !rgt_rvalid);

    // R2/R4: flow-through valid follows the previous edge's selected read.
    a_r4_lft_flow_valid: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(lft_pipe) && !lft_oe_n)
        |-> (lft_rvalid == $past(l_rd_in)));
    a_r4_rgt_flow_valid: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(rgt_pipe) && !rgt_oe_n)
        |-> (rgt_rvalid == $past(r_rd_in)));

    // R5: pipelined valid follows the selected read two edges back.
    a_r5_lft_pipe_valid: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && $past(lft_pipe) && !lft_oe_n)
        |-> (lft_rvalid == $past(l_rd_in, 2)));
    a_r5_rgt_pipe_valid: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && $past(rgt_pipe) && !rgt_oe_n)
        |-> (rgt_rvalid == $past(r_rd_in, 2)));

    // R7: pipelined output word holds when no read was captured.
    a_r7_lft_pipe_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && $past(lft_pipe) && $past(lft_pipe, 2)
         && !$past(l_rd_in, 2)) |-> $stable(lft_rdata));
    a_r7_rgt_pipe_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && $past(rgt_pipe) && $past(rgt_pipe, 2)
         && !$past(r_rd_in, 2)) |-> $stable(rgt_rdata));

    // R10: valid flags stay low on the first sample after reset.
    a_r10_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!lft_rvalid && !rgt_rvalid));

    initial begin
        assert (AW_UNUSED > 0);
    end

endmodule

bind dpram_dual_sync dpram_dual_sync_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lft_ce0_n  (lft_ce0_n),
    .lft_ce1    (lft_ce1),
    .lft_rw     (lft_rw),
    .lft_oe_n   (lft_oe_n),
    .lft_pipe   (lft_pipe),
    .lft_rdata  (lft_rdata),
    .lft_rvalid (lft_rvalid),
    .rgt_ce0_n  (rgt_ce0_n),
    .rgt_ce1    (rgt_ce1),
    .rgt_rw     (rgt_rw),
    .rgt_oe_n   (rgt_oe_n),
    .rgt_pipe   (rgt_pipe),
    .rgt_rdata  (rgt_rdata),
    .rgt_rvalid (rgt_rvalid)
);

// File: tb/dpram_dual_sync_tb.sv
`timescale 1ns/1ps
// Directed bench for the dual-port memory; inputs change 1 ns after an edge.
module dpram_dual_sync_tb;

    localparam int AW = 11;
    localparam int DW = 8;
    localparam logic [AW-1:0] TOP_ADDR = (1 << AW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lft_ce0_n = 1'b1, lft_ce1 = 1'b0, lft_rw = 1'b1, lft_oe_n = 1'b0, lft_pipe = 1'b1;
    logic rgt_ce0_n = 1'b1, rgt_ce1 = 1'b0, rgt_rw = 1'b1, rgt_oe_n = 1'b0, rgt_pipe = 1'b1;
    logic [AW-1:0] lft_addr = '0, rgt_addr = '0;
    logic [DW-1:0] lft_wdata = '0, rgt_wdata = '0;
    logic [DW-1:0] lft_rdata, rgt_rdata;
    logic lft_rvalid, rgt_rvalid;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #2.5 clk = ~clk;

    dpram_dual_sync #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .lft_ce0_n(lft_ce0_n), .lft_ce1(lft_ce1), .lft_rw(lft_rw), .lft_oe_n(lft_oe_n),
        .lft_pipe(lft_pipe), .lft_addr(lft_addr), .lft_wdata(lft_wdata),
        .lft_rdata(lft_rdata), .lft_rvalid(lft_rvalid),
        .rgt_ce0_n(rgt_ce0_n), .rgt_ce1(rgt_ce1), .rgt_rw(rgt_rw), .rgt_oe_n(rgt_oe_n),
        .rgt_pipe(rgt_pipe), .rgt_addr(rgt_addr), .rgt_wdata(rgt_wdata),
        .rgt_rdata(rgt_rdata), .rgt_rvalid(rgt_rvalid)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic lset(input logic c0n, input logic c1, input logic rw,
                        input logic [AW-1:0] a, input logic [DW-1:0] d);
        lft_ce0_n = c0n; lft_ce1 = c1; lft_rw = rw; lft_addr = a; lft_wdata = d;
    endtask

    task automatic rset(input logic c0n, input logic c1, input logic rw,
                        input logic [AW-1:0] a, input logic [DW-1:0] d);
        rgt_ce0_n = c0n; rgt_ce1 = c1; rgt_rw = rw; rgt_addr = a; rgt_wdata = d;
    endtask

    // R10: reset state of both ports (pipelined mode shows the cleared register).
    task automatic t_reset();
        repeat (3) step();
        rst_n = 1'b1;
        step();
        check("R10 lft_rvalid", 32'(lft_rvalid), 32'd0);
        check("R10 rgt_rvalid", 32'(rgt_rvalid), 32'd0);
        check("R10 lft_rdata", 32'(lft_rdata), 32'd0);
        check("R10 rgt_rdata", 32'(rgt_rdata), 32'd0);
    endtask

    // R1 R3 R4: flow-through writes and reads at both address extremes.
    task automatic t_flow();
        lft_pipe = 1'b0;
        lset(0, 1, 0, '0, 8'h5A); step();
        check("R3 write gives no valid", 32'(lft_rvalid), 32'd0);
        lset(0, 1, 0, TOP_ADDR, 8'hA5); step();
        lset(0, 1, 1, '0, 8'h00); step();
        check("R4 flow valid", 32'(lft_rvalid), 32'd1);
        check("R1 addr 0 data", 32'(lft_rdata), 32'h5A);
        lset(0, 1, 1, TOP_ADDR, 8'h00); step();
        check("R1 top addr data", 32'(lft_rdata), 32'hA5);
        lset(1, 0, 1, '0, 8'h00); step();
        check("R4 idle no valid", 32'(lft_rvalid), 32'd0);
    endtask

    // R5 R7: pipelined read one cycle later, then held through non-reads.
    task automatic t_pipe();
        rset(0, 1, 1, '0, 8'h00); step();
        check("R5 not yet valid", 32'(rgt_rvalid), 32'd0);
        rset(0, 1, 0, 11'd3, 8'h77); step();
        check("R5 pipe valid", 32'(rgt_rvalid), 32'd1);
        check("R5 pipe data", 32'(rgt_rdata), 32'h5A);
        rset(1, 0, 1, '0, 8'h00); step();
        check("R7 write cycle no valid", 32'(rgt_rvalid), 32'd0);
        check("R7 held after write", 32'(rgt_rdata), 32'h5A);
        step();
        check("R7 held after deselect", 32'(rgt_rdata), 32'h5A);
    endtask

    // R2: only ce0_n=0 with ce1=1 selects the port.
    task automatic t_enables();
        lset(0, 1, 0, 11'd5, 8'h11); step();
        lset(1, 1, 0, 11'd5, 8'hAA); step();
        check("R2 ce0_n high no valid", 32'(lft_rvalid), 32'd0);
        lset(0, 0, 0, 11'd5, 8'hBB); step();
        lset(1, 1, 1, 11'd5, 8'h00); step();
        check("R2 deselected read no valid", 32'(lft_rvalid), 32'd0);
        lset(0, 1, 1, 11'd5, 8'h00); step();
        check("R2 deselected writes ignored", 32'(lft_rdata), 32'h11);
    endtask

    // R6: output enable gates the valid flag without a clock edge.
    task automatic t_oe();
        check("R6 read valid before oe", 32'(lft_rvalid), 32'd1);
        lft_oe_n = 1'b1; #1;
        check("R6 oe_n high clears valid", 32'(lft_rvalid), 32'd0);
        lft_oe_n = 1'b0; #1;
        check("R6 oe_n low restores valid", 32'(lft_rvalid), 32'd1);
        lset(1, 0, 1, '0, 8'h00); step();
    endtask

    // R8: same-address writes on both ports keep the left data.
    task automatic t_ww();
        rgt_pipe = 1'b0;
        lset(0, 1, 0, 11'd7, 8'hC1);
        rset(0, 1, 0, 11'd7, 8'hD2); step();
        lset(1, 0, 1, '0, 8'h00);
        rset(0, 1, 1, 11'd7, 8'h00); step();
        check("R8 left wins", 32'(rgt_rdata), 32'hC1);
        rset(1, 0, 1, '0, 8'h00); step();
    endtask

    // R9: a read racing a write on the other port returns old contents.
    task automatic t_rw();
        lset(0, 1, 0, 11'd9, 8'h33); step();
        lset(0, 1, 0, 11'd9, 8'h44);
        rset(0, 1, 1, 11'd9, 8'h00); step();
        check("R9 racing read valid", 32'(rgt_rvalid), 32'd1);
        check("R9 racing read old data", 32'(rgt_rdata), 32'h33);
        lset(1, 0, 1, '0, 8'h00); step();
        check("R9 later read new data", 32'(rgt_rdata), 32'h44);
        rset(1, 0, 1, '0, 8'h00); step();
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        t_reset();
        t_flow();
        t_pipe();
        t_enables();
        t_oe();
        t_ww();
        t_rw();
        done = 1'b1;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
            $finish;
        end
    end

endmodule